// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block brings a hung I2C bus back to idle. A one-cycle request starts a fixed sequence. First it emits a one-cycle strobe that clears the controller's sticky status flags. It then waits a bounded time for any transfer in flight to finish. After that it holds the main controller in soft reset and drives SCL and SDA directly. It clocks SCL until a target that is holding SDA low lets go. It finishes with a START and then a STOP, and only then releases the soft reset.

Both lines are open-drain. An enable output at 1 pulls the pad low, and at 0 it lets the line float high. The pad levels are read back through a two-flop synchronizer before any decision uses them. Every wait is a whole number of ticks, and one tick is `TICK_DIV` clock cycles. So a single parameter maps the microsecond-scale timing onto any clock frequency.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, every output is 0: both line enables, soft reset, the clear strobe, done and fail.
- R2: Accepting a request raises `clr_status_o` for exactly one cycle, in the first cycle after the accepting edge.
- R3: `pending_i` is sampled at most `POLL_MAX` times, one sample every `POLL_GAP_T` ticks plus one cycle. The sequence moves on at the first sample that reads 0, or after the last sample even if it still reads 1. Soft reset rises 2 cycles after the accepting edge, plus (`POLL_GAP_T`·`TICK_DIV`+1) cycles for each gap taken.
- R4: `soft_rst_o` is high whenever either line enable is high. It stays high from the end of polling until the STOP settle time has run out.
- R5: With both lines released, the block checks whether SCL and SDA both read high. If they do not, it pulls SCL low for exactly `HALF_T`·`TICK_DIV` cycles, releases it for `HALF_T` ticks, and then checks again.
- R6: At most `PULSE_MAX` SCL pulses are issued. If the lines still do not both read high after the last pulse, `fail_o` is set, and the START, STOP and reset release still take place.
- R7: START pulls SDA low while SCL is released, for exactly `START_T`·`TICK_DIV` cycles. STOP then releases SDA, and soft reset stays high for a further `STOP_T`·`TICK_DIV` cycles.
- R8: `done_o` is a single-cycle pulse that rises in the same cycle in which `soft_rst_o` falls.
- R9: A request that arrives while a sequence is in progress is ignored. It produces no second clear strobe and no second done pulse.
- R10: `fail_o` holds its value after done. It is cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Recovery request strobe |
| pending_i | input | 1 | Controller reports a transfer in progress |
| scl_i | input | 1 | SCL pad level (asynchronous) |
| sda_i | input | 1 | SDA pad level (asynchronous) |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| soft_rst_o | output | 1 | Holds the main controller in reset |
| clr_status_o | output | 1 | One-cycle strobe that clears the sticky status flags |
| done_o | output | 1 | Sequence finished (pulse) |
| fail_o | output | 1 | Lines did not recover within the pulse limit |

## Verification
Some properties are checked by assertions on every cycle:
- a line is never driven without soft reset;
- SDA is never pulled while SCL is pulled;
- the done pulse is single-cycle and lines up with the release of soft reset;
- the pulse and poll counters stay within their limits;
- a request made while busy never restarts the sequence.

Other behaviour only the bench scenarios can show. These are the exact phase lengths, and the time from request to soft reset for each point at which the pending flag drops. They also include the pulse count and fail outcome for every number of clocks a stuck target needs, from none to beyond the limit, and a permanently stuck SCL.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_POLL,
    ST_POLL_WAIT,
    ST_CHECK,
    ST_SCL_LO,
    ST_SCL_HI,
    ST_START,
    ST_STOP
  } rcv_state_e;
endpackage

// File: rtl/rcv_sync.sv
module rcv_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rcv_timer.sv
// Interval timer: a start loads ticks_i; expire_o is high in the last cycle
// of a ticks_i*TICK_DIV cycle window.
module rcv_timer #(
  parameter int TICK_DIV = 100,
  parameter int CNT_W    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] ticks_i,
  output logic             expire_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_DIV - 1);

  logic             run_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      pre_q <= PRE_TOP;
      cnt_q <= ticks_i;
    end else if (run_q) begin
      if (pre_q == '0) begin
        pre_q <= PRE_TOP;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  assign expire_o = run_q && (pre_q == '0) && (cnt_q == CNT_W'(1));

  assert_start_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (ticks_i != '0));
  assert_run_count_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q != '0));
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import i2c_rcv_pkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int POLL_MAX   = 10,
  parameter int POLL_GAP_T = 500,
  parameter int HALF_T     = 100,
  parameter int PULSE_MAX  = 10,
  parameter int START_T    = 1000,
  parameter int STOP_T     = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic pending_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic soft_rst_o,
  output logic clr_status_o,
  output logic done_o,
  output logic fail_o
);
  localparam int MAX_T1 = (POLL_GAP_T > HALF_T) ? POLL_GAP_T : HALF_T;
  localparam int MAX_T2 = (START_T > STOP_T) ? START_T : STOP_T;
  localparam int MAX_T  = (MAX_T1 > MAX_T2) ? MAX_T1 : MAX_T2;
  localparam int TW     = $clog2(MAX_T + 1);
  localparam int PLW    = $clog2(POLL_MAX + 1);
  localparam int PUW    = $clog2(PULSE_MAX + 1);

  rcv_state_e     st_q, st_d;
  logic [PLW-1:0] poll_q;
  logic [PUW-1:0] pulse_q;
  logic           fail_q, done_q;
  logic           t_start, t_exp;
  logic [TW-1:0]  t_ticks;
  logic [1:0]     lines_s;
  logic           bus_free;

  rcv_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b11)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (lines_s)
  );

  rcv_timer #(.TICK_DIV(TICK_DIV), .CNT_W(TW)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (t_start),
    .ticks_i  (t_ticks),
    .expire_o (t_exp)
  );

  assign bus_free = &lines_s;

  always_comb begin
    st_d    = st_q;
    t_start = 1'b0;
    t_ticks = '0;
    unique case (st_q)
      ST_IDLE:  if (req_i) st_d = ST_CLEAR;
      ST_CLEAR: st_d = ST_POLL;
      ST_POLL: begin
        if (!pending_i || poll_q == PLW'(POLL_MAX - 1)) begin
          st_d = ST_CHECK;
        end else begin
          st_d    = ST_POLL_WAIT;
          t_start = 1'b1;
          t_ticks = TW'(POLL_GAP_T);
        end
      end
      ST_POLL_WAIT: if (t_exp) st_d = ST_POLL;
      ST_CHECK: begin
        t_start = 1'b1;
        if (bus_free || pulse_q == PUW'(PULSE_MAX)) begin
          st_d    = ST_START;
          t_ticks = TW'(START_T);
        end else begin
          st_d    = ST_SCL_LO;
          t_ticks = TW'(HALF_T);
        end
      end
      ST_SCL_LO: if (t_exp) begin
        st_d    = ST_SCL_HI;
        t_start = 1'b1;
        t_ticks = TW'(HALF_T);
      end
      ST_SCL_HI: if (t_exp) st_d = ST_CHECK;
      ST_START: if (t_exp) begin
        st_d    = ST_STOP;
        t_start = 1'b1;
        t_ticks = TW'(STOP_T);
      end
      ST_STOP: if (t_exp) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      poll_q  <= '0;
      pulse_q <= '0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_STOP) && t_exp;
      if (st_q == ST_IDLE && req_i) fail_q <= 1'b0;
      if (st_q == ST_CLEAR) begin
        poll_q  <= '0;
        pulse_q <= '0;
      end
      if (st_q == ST_POLL && st_d == ST_POLL_WAIT) poll_q <= poll_q + 1'b1;
      if (st_q == ST_CHECK && st_d == ST_SCL_LO) pulse_q <= pulse_q + 1'b1;
      // limit reached with the bus still held
      if (st_q == ST_CHECK && !bus_free && pulse_q == PUW'(PULSE_MAX)) fail_q <= 1'b1;
    end
  end

  assign scl_oe_o     = (st_q == ST_SCL_LO);
  assign sda_oe_o     = (st_q == ST_START);
  assign soft_rst_o   = (st_q == ST_CHECK) || (st_q == ST_SCL_LO) || (st_q == ST_SCL_HI) ||
                        (st_q == ST_START) || (st_q == ST_STOP);
  assign clr_status_o = (st_q == ST_CLEAR);
  assign done_o       = done_q;
  assign fail_o       = fail_q;

  assert_clear_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_status_o |=> !clr_status_o);
  assert_poll_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q < PLW'(POLL_MAX));
  assert_lines_need_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o || sda_oe_o) |-> soft_rst_o);
  assert_pulse_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q <= PUW'(PULSE_MAX));
  assert_start_scl_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> !scl_oe_o);
  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_release_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(soft_rst_o) |-> done_o);
  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && req_i) |=> (st_q != ST_CLEAR));
endmodule

// File: tb/test_i2c_bus_recover.sv
`timescale 1ns/1ps
module test_i2c_bus_recover;
  localparam int D   = 4;
  localparam int PM  = 6;
  localparam int PG  = 5;
  localparam int HT  = 3;
  localparam int XM  = 10;
  localparam int ST  = 6;
  localparam int SP  = 5;
  localparam int GAP = PG * D + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, pending = 1'b0;
  logic scl_hold = 1'b0, sda_hold = 1'b0;
  logic scl_oe, sda_oe, soft_rst, clr, done, fail;
  wire  scl_pad = !scl_oe && !scl_hold;
  wire  sda_pad = !sda_oe && !sda_hold;
  int   tests = 0, fails = 0;

  always #2 clk = ~clk;

  i2c_bus_recover #(
    .TICK_DIV(D), .POLL_MAX(PM), .POLL_GAP_T(PG), .HALF_T(HT),
    .PULSE_MAX(XM), .START_T(ST), .STOP_T(SP)
  ) i_i2c_bus_recover (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .pending_i(pending),
    .scl_i(scl_pad), .sda_i(sda_pad),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .soft_rst_o(soft_rst),
    .clr_status_o(clr), .done_o(done), .fail_o(fail)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // k: SCL clocks a stuck target needs before it frees SDA
  // pe: first edge index at which pending reads low
  task automatic run(input int k, input bit scl_stuck, input int pe, input bit extra_req);
    int n = 0, rises = 0, pulses = 0, bad_low = 0, run_len = 0;
    int t_rst = -1, clr_cnt = 0, clr_idx = -1, sda_len = 0, sda_fall = -1;
    int done_cnt = 0, done_idx = -1, rst_fall = -1, gaps = PM - 1;
    bit fail_at_done = 0, overlap = 0, prev_scl = 0, prev_sda = 0, prev_rst = 0;
    bit finished = 0;
    int exp_pulses;
    bit exp_fail;
    for (int j = 0; j < PM; j++)
      if (2 + j * GAP >= pe) begin gaps = j; break; end
    exp_pulses = scl_stuck ? XM : ((k < XM) ? k : XM);
    exp_fail   = scl_stuck || (k > XM);
    scl_hold = scl_stuck;
    sda_hold = (k > 0);
    pending  = (0 < pe);
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(fail == 1'b0, "R10 fail cleared on accept", fail, 0);
    while (!finished && n < 5000) begin
      if (clr) begin clr_cnt++; if (clr_idx < 0) clr_idx = n; end
      if (soft_rst && t_rst < 0) t_rst = n;
      if (scl_oe) run_len++;
      if (!scl_oe && prev_scl) begin
        pulses++;
        if (run_len != HT * D) bad_low++;
        run_len = 0;
        if (!scl_hold) rises++;
        if (rises >= k) sda_hold = 1'b0;
      end
      if (sda_oe) sda_len++;
      if (!sda_oe && prev_sda) sda_fall = n;
      if (sda_oe && scl_oe) overlap = 1;
      if (!soft_rst && prev_rst) rst_fall = n;
      if (done) begin done_cnt++; done_idx = n; fail_at_done = fail; end
      prev_scl = scl_oe; prev_sda = sda_oe; prev_rst = soft_rst;
      pending = (n + 1 < pe);
      req = extra_req && (n == 5 || n == t_rst + 3);
      @(negedge clk);
      n++;
      if (done_idx >= 0 && n > done_idx + 20) finished = 1;
    end
    scl_hold = 1'b0;
    chk(clr_cnt == 1 && clr_idx == 0, "R2 clear strobe", clr_cnt * 100 + clr_idx, 100);
    chk(t_rst == 2 + gaps * GAP, "R3 poll timing", t_rst, 2 + gaps * GAP);
    chk(pulses == exp_pulses, "R6 pulse count", pulses, exp_pulses);
    chk(bad_low == 0, "R5 SCL low phase length", bad_low, 0);
    chk(!overlap, "R7 SDA driven with SCL low", overlap, 0);
    chk(sda_len == ST * D, "R7 START length", sda_len, ST * D);
    chk(rst_fall - sda_fall == SP * D, "R7 STOP settle", rst_fall - sda_fall, SP * D);
    chk(rst_fall > t_rst && t_rst >= 0, "R4 reset window", rst_fall, t_rst);
    chk(done_cnt == 1 && done_idx == rst_fall, "R8 done pulse", done_idx, rst_fall);
    chk(fail_at_done == exp_fail, "R6 fail outcome", fail_at_done, exp_fail);
    chk(fail == exp_fail, "R10 fail held", fail, exp_fail);
    if (extra_req)
      chk(!soft_rst && done_cnt == 1, "R9 request while busy", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({scl_oe, sda_oe, soft_rst, clr, done, fail} == 6'b0, "R1 reset state",
        {scl_oe, sda_oe, soft_rst, clr, done, fail}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({scl_oe, sda_oe, soft_rst, clr, done, fail} == 6'b0, "R1 idle after reset",
        {scl_oe, sda_oe, soft_rst, clr, done, fail}, 0);
    for (int k = 0; k <= XM + 2; k++) run(k, 1'b0, 0, 1'b0);
    run(0, 1'b1, 0, 1'b0);
    for (int pe = 0; pe <= 2 + PM * GAP; pe += 7) run(2, 1'b0, pe, 1'b0);
    run(1000, 1'b0, 1000, 1'b1);
    run(3, 1'b0, 40, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule